// File: doc/BRIEF.md
# Character Display Host Instruction Port

This block is the host-side command front end of a dot-matrix character display controller. A host drives a parallel bus made of a register-select line, a read/write line, an 8-bit data bus and an enable strobe. The block samples the bus on each falling edge of the strobe. It decodes instruction writes and keeps a 7-bit address counter, a memory-target selector, a direction bit for the counter and a horizontal scroll amount. Each data write becomes a one-cycle memory write request that carries the target, the address and the data. The counter then steps up or down by one.

A status read returns the busy flag and the address counter. After every accepted instruction or data write the busy flag stays high for a fixed number of clock cycles. Any strobe that completes during that window is dropped. The scroll amount is given as a count of pixel columns and stops at 48. An extended-register input selects the second instruction page, which holds the scroll instruction. The memory arrays, the pixel scan-out and the shifter itself are separate blocks.

Top module: `lcd_host_port`

## Requirements
- R1: After reset the address counter is 0, the scroll output is 0, busy is low, the target is display memory (ram_sel code 0) and the counter direction is increment.
- R2: The bus is acted on only on the falling edge of bus_e. While bus_e stays high, nothing happens, however long it stays high.
- R3: A data write (rs=1, rw=0) causes exactly one cycle of ram_we, carrying ram_sel equal to the latched target, ram_addr equal to the counter value before the write, and ram_wdata equal to the bus byte.
- R4: After each data write the address counter changes by one, modulo 128. It increments when the direction bit is 0 and decrements when it is 1. The instruction 0b0000001d (ext=0, rs=0) loads the direction bit d.
- R5: With ext=0 and rs=0, three instruction writes load the counter and latch a target: 1aaaaaaa loads display memory (code 0) with a 7-bit address. 01aaaaaa loads character memory (code 1) with a 6-bit address. 0001aaaa loads segment memory (code 2) with a 4-bit address. In each case the address is zero-extended.
- R6: With ext=1 and rs=0, an instruction write with bit 7 set loads the 6-bit scroll code from bits 5..0. Bit 6 is ignored. The scroll_dots output equals the code for codes 0..47 and equals 48 for any code whose top two bits are both 1.
- R7: While rs=0, rw=1 and bus_e is high, bus_dout_en is high and bus_dout carries {busy, address counter}. A read does not set busy.
- R8: Each accepted instruction or data write holds busy high for exactly BUSY_CYCLES clock cycles. Bus patterns that decode to nothing, including ext=1 writes with bit 7 clear, do not set busy and change no state.
- R9: A strobe whose falling edge is acted on while busy is high is ignored. It changes neither the state nor the memory outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_e | input | 1 | Enable strobe; the bus is acted on at its falling edge |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_ext | input | 1 | Selects the extended instruction page |
| bus_din | input | 8 | Data bus from the host |
| bus_dout | output | 8 | Status byte {busy, address counter} |
| bus_dout_en | output | 1 | High while a status read is being driven |
| busy | output | 1 | Internal operation in progress |
| ram_we | output | 1 | One-cycle memory write request |
| ram_sel | output | 2 | Target memory: 0 display, 1 character, 2 segment |
| ram_addr | output | 7 | Write address |
| ram_wdata | output | 8 | Write data |
| scroll_dots | output | 6 | Effective horizontal scroll, 0 to 48 |

## Verification
The assertions assume that the bus inputs are synchronous to clk and that rs, rw, ext and din are held steady for the whole time bus_e is high. They also assume the host issues at most one strobe per busy window, apart from the strobe that is deliberately dropped. The stimulus raises bus_e for at least two clock cycles with the other bus lines already settled, and it releases them only after the falling edge. Except in the directed drop test, it waits well past the busy window before starting the next strobe.

// File: rtl/hif_pkg.sv
package hif_pkg;
  typedef enum logic [1:0] {
    TGT_DISP = 2'd0,
    TGT_CHAR = 2'd1,
    TGT_SEG  = 2'd2
  } ram_tgt_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_ADDR   = 3'd2,
    OP_ENTRY  = 3'd3,
    OP_SCROLL = 3'd4
  } op_e;
endpackage

// File: rtl/hif_strobe_sync.sv
module hif_strobe_sync #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e,
  input  logic              rs,
  input  logic              rw,
  input  logic              ext,
  input  logic [DATA_W-1:0] din,
  output logic              fall,
  output logic              cap_rs,
  output logic              cap_rw,
  output logic              cap_ext,
  output logic [DATA_W-1:0] cap_din
);
  logic e_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_q     <= 1'b0;
      fall    <= 1'b0;
      cap_rs  <= 1'b0;
      cap_rw  <= 1'b1;
      cap_ext <= 1'b0;
      cap_din <= '0;
    end else begin
      e_q  <= e;
      fall <= e_q & ~e;
      if (e) begin
        cap_rs  <= rs;
        cap_rw  <= rw;
        cap_ext <= ext;
        cap_din <= din;
      end
    end
  end

  // a falling edge is a single-cycle event
  assert_fall_single_R2: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/hif_decode.sv
module hif_decode
  import hif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SQ_W   = 6
) (
  input  logic              rs,
  input  logic              rw,
  input  logic              ext,
  input  logic [DATA_W-1:0] din,
  output op_e               op,
  output logic [DATA_W-2:0] addr,
  output ram_tgt_e          tgt,
  output logic              dir,
  output logic [SQ_W-1:0]   sq
);
  localparam int AC_W = DATA_W - 1;

  always_comb begin
    op   = OP_NONE;
    addr = '0;
    tgt  = TGT_DISP;
    dir  = din[0];
    sq   = din[SQ_W-1:0];
    if (!rw) begin
      if (rs) begin
        op = OP_WRITE;
      end else if (ext) begin
        if (din[DATA_W-1]) op = OP_SCROLL;
      end else if (din[DATA_W-1]) begin
        op   = OP_ADDR;
        tgt  = TGT_DISP;
        addr = din[AC_W-1:0];
      end else if (din[DATA_W-2]) begin
        op   = OP_ADDR;
        tgt  = TGT_CHAR;
        addr = AC_W'(din[DATA_W-3:0]);
      end else if (din[DATA_W-1:DATA_W-4] == 4'b0001) begin
        op   = OP_ADDR;
        tgt  = TGT_SEG;
        addr = AC_W'(din[DATA_W-5:0]);
      end else if (din[DATA_W-1:1] == (DATA_W-1)'(1)) begin
        op = OP_ENTRY;
      end
    end
  end
endmodule

// File: rtl/hif_busy_timer.sv
module hif_busy_timer #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  logic [BUSY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= BUSY_W'(BUSY_CYCLES);
      busy <= 1'b1;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      busy <= (cnt > BUSY_W'(1));
    end
  end

  assert_start_idle_R9: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  assert_busy_load_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cnt == BUSY_W'(BUSY_CYCLES));
  assert_busy_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cnt == '0);
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import hif_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SQ_W        = 6,
  parameter int SCROLL_MAX  = 48,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_e,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic              bus_ext,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  output logic              busy,
  output logic              ram_we,
  output logic [1:0]        ram_sel,
  output logic [DATA_W-2:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [SQ_W-1:0]   scroll_dots
);
  localparam int AC_W = DATA_W - 1;

  logic              fall, cap_rs, cap_rw, cap_ext;
  logic [DATA_W-1:0] cap_din;
  op_e               dec_op;
  logic [AC_W-1:0]   dec_addr;
  ram_tgt_e          dec_tgt;
  logic              dec_dir;
  logic [SQ_W-1:0]   dec_sq;
  logic              accept;

  logic [AC_W-1:0]   ac_q;
  ram_tgt_e          tgt_q;
  logic              dir_q;

  hif_strobe_sync #(.DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst(rst), .e(bus_e), .rs(bus_rs), .rw(bus_rw),
    .ext(bus_ext), .din(bus_din), .fall(fall), .cap_rs(cap_rs),
    .cap_rw(cap_rw), .cap_ext(cap_ext), .cap_din(cap_din)
  );

  hif_decode #(.DATA_W(DATA_W), .SQ_W(SQ_W)) u_dec (
    .rs(cap_rs), .rw(cap_rw), .ext(cap_ext), .din(cap_din),
    .op(dec_op), .addr(dec_addr), .tgt(dec_tgt), .dir(dec_dir), .sq(dec_sq)
  );

  assign accept = fall && !busy && (dec_op != OP_NONE);

  hif_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(accept), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q        <= '0;
      tgt_q       <= TGT_DISP;
      dir_q       <= 1'b0;
      scroll_dots <= '0;
      ram_we      <= 1'b0;
      ram_sel     <= 2'd0;
      ram_addr    <= '0;
      ram_wdata   <= '0;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
    end else begin
      ram_we      <= 1'b0;
      bus_dout    <= {busy, ac_q};
      bus_dout_en <= bus_e & bus_rw & ~bus_rs;
      if (accept) begin
        case (dec_op)
          OP_WRITE: begin
            ram_we    <= 1'b1;
            ram_sel   <= tgt_q;
            ram_addr  <= ac_q;
            ram_wdata <= cap_din;
            ac_q      <= dir_q ? ac_q - 1'b1 : ac_q + 1'b1;
          end
          OP_ADDR: begin
            ac_q  <= dec_addr;
            tgt_q <= dec_tgt;
          end
          OP_ENTRY: dir_q <= dec_dir;
          OP_SCROLL:
            scroll_dots <= (int'(dec_sq) >= SCROLL_MAX) ? SQ_W'(SCROLL_MAX) : dec_sq;
          default: ;
        endcase
      end
    end
  end

  assert_we_idle_R9: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !$past(busy));
  assert_we_busy_R8: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);
  assert_we_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);
  assert_ac_step_R4: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ac_q == ram_addr + 1'b1) || (ac_q == ram_addr - 1'b1));
  assert_scroll_max_R6: assert property (@(posedge clk) disable iff (rst)
    int'(scroll_dots) <= SCROLL_MAX);
  assert_status_R7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> bus_dout == {$past(busy), $past(ac_q)});
endmodule

// File: tb/test_lcd_host_port.sv
module test_lcd_host_port;
  localparam int BUSY = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b1, bus_ext = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic bus_dout_en, busy, ram_we;
  logic [1:0] ram_sel;
  logic [6:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [5:0] scroll_dots;

  int checks = 0, errors = 0;
  int we_cnt = 0, busy_cnt = 0, we_double = 0;
  logic prev_we = 1'b0;
  logic [1:0] last_sel;
  logic [6:0] last_addr;
  logic [7:0] last_data;

  always #2 clk = ~clk;

  lcd_host_port #(.BUSY_CYCLES(BUSY)) i_lcd_host_port (
    .clk(clk), .rst(rst), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_ext(bus_ext), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .busy(busy), .ram_we(ram_we),
    .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .scroll_dots(scroll_dots)
  );

  always @(negedge clk) begin
    if (ram_we) begin
      we_cnt++;
      last_sel  = ram_sel;
      last_addr = ram_addr;
      last_data = ram_wdata;
      if (prev_we) we_double++;
    end
    if (busy) busy_cnt++;
    prev_we = ram_we;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic rs, input logic rw, input logic ext, input logic [7:0] d);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_ext = ext; bus_din = d; bus_e = 1'b1;
    repeat (2) @(negedge clk);
    bus_e = 1'b0;
  endtask

  task automatic settle();
    repeat (BUSY + 5) @(negedge clk);
  endtask

  task automatic wr(input logic rs, input logic ext, input logic [7:0] d);
    strobe(rs, 1'b0, ext, d);
    settle();
  endtask

  task automatic rd_status(output logic [7:0] v, output logic en);
    @(negedge clk);
    bus_rs = 1'b0; bus_rw = 1'b1; bus_ext = 1'b0; bus_e = 1'b1;
    repeat (2) @(negedge clk);
    v = bus_dout; en = bus_dout_en;
    bus_e = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] st;
    logic en;
    int w0, b0, exp_ac;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(scroll_dots == 6'd0, "R1 scroll", scroll_dots, 0);
    chk(bus_dout_en == 1'b0, "R1 dout_en", bus_dout_en, 0);
    b0 = busy_cnt;
    rd_status(st, en);
    chk(st == 8'h00, "R1 counter", st, 0);
    chk(en == 1'b1, "R7 dout_en", en, 1);
    chk(busy_cnt == b0, "R7 read sets no busy", busy_cnt - b0, 0);
    wr(1'b1, 1'b0, 8'h5A);
    chk(we_cnt == 1 && last_sel == 2'd0 && last_addr == 7'd0 && last_data == 8'h5A,
        "R1 default target/addr", {last_sel, last_addr}, 0);
    rd_status(st, en);
    chk(st == 8'h01, "R1 default increment", st, 1);

    // R2 strobe held high: no action before the falling edge
    @(negedge clk);
    w0 = we_cnt;
    bus_rs = 1'b1; bus_rw = 1'b0; bus_ext = 1'b0; bus_din = 8'hC3; bus_e = 1'b1;
    repeat (20) @(negedge clk);
    chk(we_cnt == w0 && busy == 1'b0, "R2 no action while high", we_cnt - w0, 0);
    b0 = busy_cnt;
    bus_e = 1'b0;
    settle();
    chk(we_cnt == w0 + 1 && last_data == 8'hC3, "R2 action on fall", we_cnt - w0, 1);
    chk(busy_cnt - b0 == BUSY, "R8 busy length", busy_cnt - b0, BUSY);

    // R5/R3 display memory: every address
    for (int a = 0; a < 128; a++) begin
      wr(1'b0, 1'b0, 8'h80 | 8'(a));
      wr(1'b1, 1'b0, 8'(a * 3 + 1));
      chk(last_sel == 2'd0 && last_addr == 7'(a) && last_data == 8'(a * 3 + 1),
          "R5 display addr set", last_addr, a);
    end
    // R5 character memory: every address
    for (int a = 0; a < 64; a++) begin
      wr(1'b0, 1'b0, 8'h40 | 8'(a));
      wr(1'b1, 1'b0, 8'(255 - a));
      chk(last_sel == 2'd1 && last_addr == 7'(a) && last_data == 8'(255 - a),
          "R5 character addr set", {last_sel, last_addr}, {2'd1, 7'(a)});
    end
    // R5 segment memory: every address
    for (int a = 0; a < 16; a++) begin
      wr(1'b0, 1'b0, 8'h10 | 8'(a));
      wr(1'b1, 1'b0, 8'(a + 100));
      chk(last_sel == 2'd2 && last_addr == 7'(a) && last_data == 8'(a + 100),
          "R5 segment addr set", {last_sel, last_addr}, {2'd2, 7'(a)});
    end
    // R3 target stays latched across writes
    wr(1'b1, 1'b0, 8'h11);
    chk(last_sel == 2'd2 && we_double == 0, "R3 target latched, single pulse", last_sel, 2);

    // R4 increment wrap 127 -> 0
    wr(1'b0, 1'b0, 8'hFF);
    wr(1'b1, 1'b0, 8'h01);
    rd_status(st, en);
    chk(st[6:0] == 7'd0, "R4 increment wrap", st[6:0], 0);
    // R4 decrement and wrap 0 -> 127
    wr(1'b0, 1'b0, 8'h03);
    wr(1'b0, 1'b0, 8'h80);
    wr(1'b1, 1'b0, 8'h02);
    chk(last_addr == 7'd0, "R4 write addr before step", last_addr, 0);
    rd_status(st, en);
    chk(st[6:0] == 7'd127, "R4 decrement wrap", st[6:0], 127);
    exp_ac = 127;
    for (int k = 0; k < 5; k++) begin
      wr(1'b1, 1'b0, 8'(k));
      exp_ac = (exp_ac + 127) % 128;
    end
    rd_status(st, en);
    chk(int'(st[6:0]) == exp_ac, "R4 repeated decrement", st[6:0], exp_ac);
    wr(1'b0, 1'b0, 8'h02);

    // R6 all scroll codes, bit 6 toggled
    for (int c = 0; c < 64; c++) begin
      wr(1'b0, 1'b1, 8'h80 | ((c & 1) ? 8'h40 : 8'h00) | 8'(c));
      chk(int'(scroll_dots) == ((c >= 48) ? 48 : c), "R6 scroll code",
          scroll_dots, (c >= 48) ? 48 : c);
    end

    // R8 patterns that decode to nothing
    wr(1'b0, 1'b0, 8'h83);
    b0 = busy_cnt; w0 = we_cnt;
    wr(1'b0, 1'b1, 8'h7F);
    wr(1'b0, 1'b0, 8'h00);
    wr(1'b0, 1'b0, 8'h08);
    chk(busy_cnt == b0, "R8 no busy on ignored pattern", busy_cnt - b0, 0);
    chk(scroll_dots == 6'd48 && we_cnt == w0, "R8 ignored pattern no state", scroll_dots, 48);
    rd_status(st, en);
    chk(st[6:0] == 7'd3, "R8 ignored pattern counter", st[6:0], 3);
    // ext=0 with bit 7 set is an address set, not scroll
    wr(1'b0, 1'b0, 8'h85);
    chk(scroll_dots == 6'd48, "R6 scroll needs ext", scroll_dots, 48);

    // R9 strobe during busy is dropped
    w0 = we_cnt;
    strobe(1'b1, 1'b0, 1'b0, 8'hAA);
    @(negedge clk);
    strobe(1'b1, 1'b0, 1'b0, 8'hBB);
    settle();
    chk(we_cnt == w0 + 1 && last_data == 8'hAA, "R9 second strobe dropped", we_cnt - w0, 1);
    rd_status(st, en);
    chk(st[6:0] == 7'd6, "R9 counter stepped once", st[6:0], 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule